// File: doc/BRIEF.md
# Receive Packet FIFO with In-Band Status

This block sits between a network MAC receive path and a DMA engine. Frame words arrive as a valid/data/last stream. Each word is stored in a single FIFO together with a two-bit tag. Error reports for a frame travel in order through the same FIFO as ordinary entries, so a report is only acted on once every entry written before it has left the read head. Per-type error counters are updated from the read side, at the moment a report entry is consumed.

On the write side, the admission decision is made on the first beat of each frame. A frame is admitted only when the free space can hold one maximum-sized frame plus one report entry. A frame that is refused is discarded whole. An overflow report is queued in its place, but only if the FIFO is not already full; when it is full the report is lost, so the counters undercount during sustained overflow. An admitted frame that ends with a CRC or length error strobe is stored and delivered as normal, followed by a report entry. Incoming frames are at most `MAX_FRAME` words long.

On the read side, frame words are handed to the DMA only while a descriptor is available. Report entries at the head are consumed without a descriptor. The descriptor request pulses only when a new frame starts arriving. A frame that is stuck at the head therefore blocks every entry behind it, and it never requests a descriptor again on its own.

Top module: `rxpkt_status_fifo`

## Requirements
- R1: Stored entries carry tag 00 for a frame word, 01 for the final word of a frame and 10 for a report. `out_last` is high with `out_valid` exactly on the final word of each frame, and `out_data` carries the words in arrival order.
- R2: If a frame's first beat finds fewer than `MAX_FRAME`+1 free entries, none of that frame's words reach the output. An overflow report (type code 0 in the low data bits) is queued when the FIFO is not full.
- R3: A refused frame that arrives while `fifo_full` is high queues no report, and the overflow counter does not count it.
- R4: An admitted frame whose last beat carries `in_crc_err` or `in_len_err` is delivered whole and is followed by one report. CRC (type code 1) takes priority over length (type code 2) when both strobes are set.
- R5: A counter changes only when its report is consumed at the read head. Reports queued behind a frame that has no descriptor leave the counters unchanged until that frame has been released.
- R6: A report at the read head is consumed on the next clock edge whether or not `desc_avail` is high, and it never raises `out_valid`.
- R7: `out_valid` is high only while `desc_avail` is high and a frame word is at the head.
- R8: `desc_req` pulses for one cycle in the cycle after the first beat of every incoming frame, whether that frame is admitted or refused. A rise of `desc_avail` alone never raises it.
- R9: Each counter is `CW` bits wide and holds at its all-ones value instead of wrapping.
- R10: `stat_clr` zeroes all counters on the next edge and wins over a simultaneous increment.
- R11: `fifo_full` and `fifo_empty` are registered and are never high together. `fifo_full` is high once all `DEPTH` entries are occupied.
- R12: After reset `fifo_empty` is 1, while `fifo_full`, `out_valid`, `desc_req` and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming frame word valid |
| in_data | input | DW | Incoming frame word |
| in_last | input | 1 | Final word of the incoming frame |
| in_crc_err | input | 1 | CRC error, sampled with the final word |
| in_len_err | input | 1 | Length error, sampled with the final word |
| desc_avail | input | 1 | A receive descriptor is free |
| desc_req | output | 1 | One-cycle descriptor request on frame arrival |
| out_valid | output | 1 | Frame word released to the DMA this cycle |
| out_data | output | DW | Released frame word |
| out_last | output | 1 | Released word ends its frame |
| stat_clr | input | 1 | Synchronous clear of all counters |
| cnt_ovf | output | CW | Overflow report count |
| cnt_crc | output | CW | CRC error report count |
| cnt_len | output | CW | Length error report count |
| fifo_full | output | 1 | All entries occupied (registered) |
| fifo_empty | output | 1 | No entries occupied (registered) |

## Verification
The bench builds the block with `DEPTH`=16, `MAX_FRAME`=4 and `CW`=3. With these values, three four-word frames push the FIFO past its admission limit, and four refused frames fill it to the top, so refused frames that find it full and lose their reports come within a few dozen cycles. The three-bit counters reach their all-ones value after a handful of reports, which brings saturation within reach together with the lost-report undercount. The 16-bit data width lets every delivered word carry a unique pattern for ordering checks.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;

    typedef enum logic [1:0] {
        TAG_DATA = 2'b00,
        TAG_EOF  = 2'b01,
        TAG_STAT = 2'b10
    } tag_e;

    typedef enum logic [1:0] {
        ERR_OVF = 2'd0,
        ERR_CRC = 2'd1,
        ERR_LEN = 2'd2
    } err_e;

    localparam int NUM_ERR = 3;

    // CRC outranks length when both are flagged on one frame
    function automatic err_e pick_err(input logic crc, input logic len);
        if (crc)
            return ERR_CRC;
        else if (len)
            return ERR_LEN;
        else
            return ERR_OVF;
    endfunction

endpackage

// File: rtl/rxpf_wr_ctl.sv
module rxpf_wr_ctl
    import rxpf_pkg::*;
#(
    parameter int DW        = 16,
    parameter int DEPTH     = 64,
    parameter int MAX_FRAME = 16,
    parameter int CNTW      = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_data,
    input  logic            in_last,
    input  logic            in_crc_err,
    input  logic            in_len_err,
    input  logic [CNTW-1:0] level,
    input  logic            full,
    output logic            wr0_en,
    output tag_e            wr0_tag,
    output logic [DW-1:0]   wr0_data,
    output logic            wr1_en,
    output tag_e            wr1_tag,
    output logic [DW-1:0]   wr1_data,
    output logic            req_pulse
);

    // highest occupancy at which a whole frame plus one report still fits
    localparam logic [CNTW-1:0] ADMIT_MAX = CNTW'(DEPTH - MAX_FRAME - 1);

    logic in_frame_q;
    logic drop_q;
    logic req_q;
    logic start;
    logic admit;
    logic take;
    logic bad;

    assign start = in_valid && !in_frame_q;
    assign admit = (level <= ADMIT_MAX);
    assign take  = in_valid && (start ? admit : !drop_q);
    assign bad   = in_crc_err || in_len_err;

    always_comb begin
        wr0_en   = 1'b0;
        wr0_tag  = TAG_DATA;
        wr0_data = in_data;
        wr1_en   = 1'b0;
        wr1_tag  = TAG_STAT;
        wr1_data = {{(DW-2){1'b0}}, pick_err(in_crc_err, in_len_err)};
        if (take) begin
            wr0_en  = 1'b1;
            wr0_tag = in_last ? TAG_EOF : TAG_DATA;
            wr1_en  = in_last && bad;
        end else if (start && !full) begin
            wr0_en   = 1'b1;
            wr0_tag  = TAG_STAT;
            wr0_data = {{(DW-2){1'b0}}, ERR_OVF};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            drop_q     <= 1'b0;
            req_q      <= 1'b0;
        end else begin
            req_q <= start;
            if (in_valid) begin
                if (in_last) begin
                    in_frame_q <= 1'b0;
                    drop_q     <= 1'b0;
                end else if (start) begin
                    in_frame_q <= 1'b1;
                    drop_q     <= !admit;
                end
            end
        end
    end

    assign req_pulse = req_q;

endmodule

// File: rtl/rxpf_store.sv
module rxpf_store
    import rxpf_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int CNTW  = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr0_en,
    input  tag_e            wr0_tag,
    input  logic [DW-1:0]   wr0_data,
    input  logic            wr1_en,
    input  tag_e            wr1_tag,
    input  logic [DW-1:0]   wr1_data,
    input  logic            pop,
    output tag_e            head_tag,
    output logic [DW-1:0]   head_data,
    output logic [CNTW-1:0] level,
    output logic            full,
    output logic            empty
);

    localparam logic [CNTW-1:0] FULL_LVL = CNTW'(DEPTH);

    tag_e            mem_tag  [DEPTH];
    logic [DW-1:0]   mem_data [DEPTH];
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   rptr;
    logic [AW-1:0]   wptr_p1;
    logic [CNTW-1:0] level_q;
    logic [CNTW-1:0] level_n;
    logic [CNTW-1:0] n_wr;
    logic            full_q;
    logic            empty_q;

    assign wptr_p1 = wptr + AW'(1);
    assign n_wr    = CNTW'(wr0_en) + CNTW'(wr1_en);
    assign level_n = level_q + n_wr - CNTW'(pop);

    always_ff @(posedge clk) begin
        if (wr0_en) begin
            mem_tag[wptr]  <= wr0_tag;
            mem_data[wptr] <= wr0_data;
        end
        if (wr1_en) begin
            mem_tag[wptr_p1]  <= wr1_tag;
            mem_data[wptr_p1] <= wr1_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            level_q <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            wptr    <= wptr + AW'(n_wr);
            rptr    <= rptr + AW'(pop);
            level_q <= level_n;
            full_q  <= (level_n == FULL_LVL);
            empty_q <= (level_n == '0);
        end
    end

    assign head_tag  = mem_tag[rptr];
    assign head_data = mem_data[rptr];
    assign level     = level_q;
    assign full      = full_q;
    assign empty     = empty_q;

endmodule

// File: rtl/rxpf_stat_cnt.sv
module rxpf_stat_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            count_q <= '0;
        else if (inc && (count_q != '1))
            count_q <= count_q + CW'(1);
    end

    assign count = count_q;

endmodule

// File: rtl/rxpkt_status_fifo.sv
module rxpkt_status_fifo
    import rxpf_pkg::*;
#(
    parameter int DW        = 16,
    parameter int DEPTH     = 64,
    parameter int MAX_FRAME = 16,
    parameter int CW        = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    input  logic          in_crc_err,
    input  logic          in_len_err,
    input  logic          desc_avail,
    output logic          desc_req,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_last,
    input  logic          stat_clr,
    output logic [CW-1:0] cnt_ovf,
    output logic [CW-1:0] cnt_crc,
    output logic [CW-1:0] cnt_len,
    output logic          fifo_full,
    output logic          fifo_empty
);

    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = AW + 1;

    logic            wr0_en;
    tag_e            wr0_tag;
    logic [DW-1:0]   wr0_data;
    logic            wr1_en;
    tag_e            wr1_tag;
    logic [DW-1:0]   wr1_data;
    logic [CNTW-1:0] level;
    logic            full;
    logic            empty;
    tag_e            head_tag;
    logic [DW-1:0]   head_data;
    logic            pop_stat;
    logic            pop_data;
    logic [CW-1:0]   counts [NUM_ERR];

    rxpf_wr_ctl #(
        .DW(DW), .DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME), .CNTW(CNTW)
    ) u_wr (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_crc_err(in_crc_err), .in_len_err(in_len_err),
        .level(level), .full(full),
        .wr0_en(wr0_en), .wr0_tag(wr0_tag), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_tag(wr1_tag), .wr1_data(wr1_data),
        .req_pulse(desc_req)
    );

    rxpf_store #(
        .DW(DW), .DEPTH(DEPTH), .AW(AW), .CNTW(CNTW)
    ) u_store (
        .clk(clk), .rst(rst),
        .wr0_en(wr0_en), .wr0_tag(wr0_tag), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_tag(wr1_tag), .wr1_data(wr1_data),
        .pop(pop_stat || pop_data),
        .head_tag(head_tag), .head_data(head_data),
        .level(level), .full(full), .empty(empty)
    );

    // reports leave without a descriptor; frame words wait for one
    assign pop_stat = !empty && (head_tag == TAG_STAT);
    assign pop_data = !empty && (head_tag != TAG_STAT) && desc_avail;

    generate
        for (genvar g = 0; g < NUM_ERR; g++) begin : g_cnt
            rxpf_stat_cnt #(.CW(CW)) u_cnt (
                .clk(clk), .rst(rst), .clr(stat_clr),
                .inc(pop_stat && (head_data[1:0] == 2'(g))),
                .count(counts[g])
            );
        end
    endgenerate

    assign out_valid  = pop_data;
    assign out_data   = head_data;
    assign out_last   = (head_tag == TAG_EOF);
    assign cnt_ovf    = counts[ERR_OVF];
    assign cnt_crc    = counts[ERR_CRC];
    assign cnt_len    = counts[ERR_LEN];
    assign fifo_full  = full;
    assign fifo_empty = empty;

endmodule

// File: rtl/rxpf_checker.sv
module rxpf_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          desc_avail,
    input logic          desc_req,
    input logic          out_valid,
    input logic          stat_clr,
    input logic [CW-1:0] cnt_ovf,
    input logic [CW-1:0] cnt_crc,
    input logic [CW-1:0] cnt_len,
    input logic          fifo_full,
    input logic          fifo_empty
);

    p_release_needs_desc_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> desc_avail);

    p_req_follows_arrival_r8: assert property (@(posedge clk) disable iff (rst)
        desc_req |-> $past(in_valid));

    p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    p_ovf_saturates_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_ovf == '1 && !stat_clr) |=> (cnt_ovf == '1));

    p_crc_saturates_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_crc == '1 && !stat_clr) |=> (cnt_crc == '1));

    p_clear_zeroes_r10: assert property (@(posedge clk) disable iff (rst)
        stat_clr |=> (cnt_ovf == '0 && cnt_crc == '0 && cnt_len == '0));

    p_counters_hold_on_frame_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !stat_clr) |=> ($stable(cnt_ovf) && $stable(cnt_crc) && $stable(cnt_len)));

    p_ovf_single_step_r6: assert property (@(posedge clk) disable iff (rst)
        !stat_clr |=> (cnt_ovf == $past(cnt_ovf) || cnt_ovf == $past(cnt_ovf) + 1'b1));

endmodule

bind rxpkt_status_fifo rxpf_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .desc_avail(desc_avail),
    .desc_req(desc_req), .out_valid(out_valid), .stat_clr(stat_clr),
    .cnt_ovf(cnt_ovf), .cnt_crc(cnt_crc), .cnt_len(cnt_len),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
);

// File: tb/sim_rxpkt_status_fifo.sv
`timescale 1ns/1ps
module sim_rxpkt_status_fifo;

    localparam int DW = 16;
    localparam int DEPTH = 16;
    localparam int MAX_FRAME = 4;
    localparam int CW = 3;
    localparam int CMAX = (1 << CW) - 1;

    typedef struct packed {
        logic [3:0] len;
        logic       crc;
        logic       lerr;
        logic       exp_crc;
        logic       exp_len;
    } vec_t;

    // frame length, error strobes, expected counter steps (R4: CRC outranks length)
    localparam vec_t VEC [0:5] = '{
        '{4'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd2, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'd4, 1'b0, 1'b1, 1'b0, 1'b1},
        '{4'd3, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'd4, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_last = 1'b0;
    logic          in_crc_err = 1'b0;
    logic          in_len_err = 1'b0;
    logic          desc_avail = 1'b0;
    logic          stat_clr = 1'b0;
    logic          desc_req;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_last;
    logic [CW-1:0] cnt_ovf;
    logic [CW-1:0] cnt_crc;
    logic [CW-1:0] cnt_len;
    logic          fifo_full;
    logic          fifo_empty;

    int n_chk = 0;
    int n_fail = 0;
    int rx_n = 0;
    int req_n = 0;
    logic [DW-1:0] rx_data [512];
    logic          rx_last [512];
    int exp_ovf = 0;
    int exp_crc = 0;
    int exp_len = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rxpkt_status_fifo #(
        .DW(DW), .DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME), .CW(CW)
    ) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_crc_err(in_crc_err), .in_len_err(in_len_err),
        .desc_avail(desc_avail), .desc_req(desc_req), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .stat_clr(stat_clr),
        .cnt_ovf(cnt_ovf), .cnt_crc(cnt_crc), .cnt_len(cnt_len),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                rx_data[rx_n] <= out_data;
                rx_last[rx_n] <= out_last;
                rx_n <= rx_n + 1;
            end
            if (desc_req)
                req_n <= req_n + 1;
        end
    end

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input int len, input int base, input bit crc, input bit lerr);
        for (int i = 0; i < len; i++) begin
            in_valid   = 1'b1;
            in_data    = DW'(base + i);
            in_last    = (i == len - 1);
            in_crc_err = crc && (i == len - 1);
            in_len_err = lerr && (i == len - 1);
            @(posedge clk);
            #1;
        end
        in_valid   = 1'b0;
        in_last    = 1'b0;
        in_crc_err = 1'b0;
        in_len_err = 1'b0;
    endtask

    task automatic chk_counters(input string req);
        chk(req, int'(cnt_ovf), exp_ovf);
        chk(req, int'(cnt_crc), exp_crc);
        chk(req, int'(cnt_len), exp_len);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int mark;
        int rmark;
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R12 / R11: reset state
        chk("R12 out_valid", int'(out_valid), 0);
        chk("R12 desc_req", int'(desc_req), 0);
        chk("R11 fifo_empty", int'(fifo_empty), 1);
        chk("R11 fifo_full", int'(fifo_full), 0);
        chk_counters("R12 counters");

        // table walk: R1 delivery and ordering, R4 error reports
        desc_avail = 1'b1;
        for (int v = 0; v < 6; v++) begin
            mark = rx_n;
            send(int'(VEC[v].len), 16'h1000 * (v + 1), VEC[v].crc, VEC[v].lerr);
            wait_cyc(6);
            exp_crc = sat(exp_crc + int'(VEC[v].exp_crc));
            exp_len = sat(exp_len + int'(VEC[v].exp_len));
            chk("R4 words delivered", rx_n - mark, int'(VEC[v].len));
            for (int i = 0; i < int'(VEC[v].len); i++) begin
                chk("R1 data order", int'(rx_data[mark + i]), 16'h1000 * (v + 1) + i);
                chk("R1 last flag", int'(rx_last[mark + i]), (i == int'(VEC[v].len) - 1) ? 1 : 0);
            end
            chk("R4 crc count", int'(cnt_crc), exp_crc);
            chk("R4 len count", int'(cnt_len), exp_len);
        end

        // R7 / R8: no descriptor, request only on arrival
        desc_avail = 1'b0;
        mark  = rx_n;
        rmark = req_n;
        send(3, 16'h2000, 1'b0, 1'b0);
        wait_cyc(4);
        chk("R8 one request per frame", req_n - rmark, 1);
        chk("R7 held without descriptor", int'(out_valid), 0);
        chk("R7 nothing released", rx_n - mark, 0);
        chk("R11 not empty", int'(fifo_empty), 0);
        desc_avail = 1'b1;
        wait_cyc(6);
        chk("R8 no request on descriptor rise", req_n - rmark, 1);
        chk("R7 released after descriptor", rx_n - mark, 3);
        chk("R7 first word", int'(rx_data[mark]), 16'h2000);

        // R5: report blocked behind a frame with no descriptor
        desc_avail = 1'b0;
        mark = rx_n;
        send(2, 16'h3000, 1'b0, 1'b0);
        send(2, 16'h3100, 1'b1, 1'b0);
        wait_cyc(5);
        chk("R5 crc count blocked", int'(cnt_crc), exp_crc);
        chk("R5 still queued", int'(fifo_empty), 0);
        desc_avail = 1'b1;
        wait_cyc(8);
        exp_crc = sat(exp_crc + 1);
        chk("R5 crc count after release", int'(cnt_crc), exp_crc);
        chk("R5 words delivered", rx_n - mark, 4);
        chk("R5 order", int'(rx_data[mark + 2]), 16'h3100);
        chk("R11 drained", int'(fifo_empty), 1);

        // R6: report consumed without a descriptor in one cycle
        send(1, 16'h4000, 1'b1, 1'b0);
        wait_cyc(1);
        desc_avail = 1'b0;
        chk("R6 report not shown", int'(out_valid), 0);
        chk("R6 count before consume", int'(cnt_crc), exp_crc);
        chk("R6 report queued", int'(fifo_empty), 0);
        wait_cyc(1);
        exp_crc = sat(exp_crc + 1);
        chk("R6 count after consume", int'(cnt_crc), exp_crc);
        chk("R6 fifo empty", int'(fifo_empty), 1);

        // R10: clear held through a report pop wins over increment
        desc_avail = 1'b1;
        stat_clr = 1'b1;
        send(2, 16'h4100, 1'b0, 1'b1);
        wait_cyc(5);
        stat_clr = 1'b0;
        wait_cyc(1);
        exp_ovf = 0; exp_crc = 0; exp_len = 0;
        chk_counters("R10 clear wins");

        // R2 / R3 / R11: fill past admission, then to full
        for (int round = 0; round < 2; round++) begin
            desc_avail = 1'b0;
            mark  = rx_n;
            rmark = req_n;
            for (int f = 0; f < 9; f++)
                send(4, 16'h5000 + 16'h0100 * f, 1'b0, 1'b0);
            wait_cyc(1);
            chk("R11 full flag", int'(fifo_full), 1);
            chk("R8 request per arrival", req_n - rmark, 9);
            chk("R2 refused frames not counted yet", int'(cnt_ovf), exp_ovf);
            desc_avail = 1'b1;
            wait_cyc(30);
            exp_ovf = sat(exp_ovf + 4);
            chk("R3 overflow count undercounts", int'(cnt_ovf), exp_ovf);
            chk("R2 only admitted frames", rx_n - mark, 12);
            for (int i = 0; i < 12; i++)
                chk("R2 admitted data", int'(rx_data[mark + i]), 16'h5000 + 16'h0100 * (i / 4) + (i % 4));
            chk("R11 empty after drain", int'(fifo_empty), 1);
            chk("R11 not full after drain", int'(fifo_full), 0);
        end
        chk("R9 saturated", int'(cnt_ovf), CMAX);

        stat_clr = 1'b1;
        wait_cyc(1);
        stat_clr = 1'b0;
        exp_ovf = 0;
        chk_counters("R10 clear");

        done = 1'b1;
        finish_run();
    end

endmodule